// File: doc/BRIEF.md
# Register-Driven Display AUX Request Engine

This block gives a host processor a small byte-wide register window for building one display AUX-style request and collecting its outcome. The host loads a 20-bit target address, a 4-bit request code and a payload length, pushes any write bytes into an internal write queue, and sets a launch bit. The engine then hands the request to a link-side port, streams write bytes out for write-type requests, and collects returned bytes into a read queue for read-type requests. It waits for a response beat that carries a 3-bit outcome and a 5-bit returned count.

After the response arrives, the launch bit drops. The host reads the status byte and drains the read bytes one at a time through a pop-on-read data register. A write of 0xFF to the configuration register clears both queues and the status before the next request. Electrical signalling, line coding and retry handling sit beyond the link port.

Top module: `aux_req_engine`

## Requirements
- R1: After reset, every readable register returns 0x00, and `lnk_req_valid_o`, `lnk_wr_valid_o` and `lnk_rsp_ready_o` are low.
- R2: Offsets 0x7D and 0x7E hold address bits 7:0 and 15:8. Offset 0x7F holds address bits 19:16 in bits 3:0 and the request code in bits 7:4. All three read back as written and drive `lnk_req_addr_o` and `lnk_req_cmd_o`. Read data appears on `reg_rdata_o` in the cycle after the read strobe.
- R3: Offset 0x80 keeps bit 7 (no payload) and bits 3:0 (length minus one), and reads bits 6:4 as 0. `lnk_req_len_o` is 0 when bit 7 is set and bits 3:0 plus one otherwise.
- R4: Writing a value with bit 0 set to offset 0x83 while idle raises `lnk_req_valid_o`. It also makes bit 0 of 0x83 read 1. The request fields are held stable until `lnk_req_ready_i` is seen.
- R5: A request code with bit 0 clear and a nonzero length is a write. After the request is accepted, exactly that many bytes leave on the write stream, in push order. A missing byte is sent as 0x00. Read codes (bit 0 set) and zero-length requests send no bytes.
- R6: For read codes, bytes accepted on the read stream are returned in arrival order by reads of offset 0x82, one byte per read. For write codes, returned bytes are discarded.
- R7: The response beat ends the request. Offset 0x84 then reads {outcome[2:0], count[4:0]}, bit 0 of 0x83 reads 0, and all link-side valid/ready outputs are low.
- R8: Each queue holds 16 bytes. A push into a full queue is dropped, and a pop of an empty queue returns 0x00.
- R9: While a request is in progress, every register write is ignored. This includes a relaunch, a flush and address updates.
- R10: Writing 0xFF to offset 0x76 while idle empties both queues and clears the status. Any other value written there has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_we_i | input | 1 | Write strobe |
| reg_re_i | input | 1 | Read strobe |
| reg_rdata_o | output | 8 | Read data, registered |
| lnk_req_valid_o | output | 1 | Request header valid |
| lnk_req_ready_i | input | 1 | Request header accepted |
| lnk_req_addr_o | output | 20 | Target address |
| lnk_req_cmd_o | output | 4 | Request code |
| lnk_req_len_o | output | 5 | Payload byte count, 0 to 16 |
| lnk_wr_valid_o | output | 1 | Write byte valid |
| lnk_wr_ready_i | input | 1 | Write byte accepted |
| lnk_wr_data_o | output | 8 | Write byte |
| lnk_rd_valid_i | input | 1 | Returned byte valid |
| lnk_rd_ready_o | output | 1 | Returned byte accepted |
| lnk_rd_data_i | input | 8 | Returned byte |
| lnk_rsp_valid_i | input | 1 | Response beat valid |
| lnk_rsp_ready_o | output | 1 | Response beat accepted |
| lnk_rsp_code_i | input | 3 | Outcome code |
| lnk_rsp_cnt_i | input | 5 | Returned byte count |

## Verification
The checker watches the link-side handshakes on every cycle. It checks that the request header holds still until it is taken and that only one phase is active at a time. It also checks that write bytes go out only for write codes with a payload, that the response beat closes the request, that address writes during a request leave the address alone, and that neither queue count passes its depth. The byte contents are left to the bench scenarios, which pit the engine against a scripted link partner. These cover write-stream order and zero fill, read-queue order and drops, status packing, length encoding, flush versus other configuration values, and the writes ignored while busy.

// File: rtl/aux_eng_pkg.sv
package aux_eng_pkg;
  localparam logic [7:0] OFS_CFG  = 8'h76;
  localparam logic [7:0] OFS_ADR0 = 8'h7D;
  localparam logic [7:0] OFS_ADR1 = 8'h7E;
  localparam logic [7:0] OFS_ADR2 = 8'h7F;
  localparam logic [7:0] OFS_LEN  = 8'h80;
  localparam logic [7:0] OFS_WDAT = 8'h81;
  localparam logic [7:0] OFS_RDAT = 8'h82;
  localparam logic [7:0] OFS_CTL  = 8'h83;
  localparam logic [7:0] OFS_STAT = 8'h84;
  localparam logic [7:0] CFG_FLUSH = 8'hFF;

  localparam int ADDR_W = 20;
  localparam int CMD_W  = 4;
  localparam int OUTC_W = 3;
  localparam int RCNT_W = 5;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_REQ,
    SQ_WR,
    SQ_WAIT
  } sq_state_e;
endpackage

// File: rtl/aux_byte_fifo.sv
module aux_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] cnt_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop, empty;

  assign empty   = (cnt == '0);
  assign do_push = push_i && (cnt != FULL);
  assign do_pop  = pop_i && !empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else if (flush_i) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem[wptr] <= data_i;
  end

  assign head_o = empty ? '0 : mem[rptr];
  assign cnt_o  = cnt;
endmodule

// File: rtl/aux_seq.sv
module aux_seq
  import aux_eng_pkg::*;
#(
  parameter int LEN_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic             is_wr_i,
  input  logic [LEN_W-1:0] nbytes_i,
  input  logic             req_ready_i,
  input  logic             wr_ready_i,
  input  logic             rsp_valid_i,
  output logic             busy_o,
  output logic             req_valid_o,
  output logic             wr_valid_o,
  output logic             wr_pop_o,
  output logic             wait_o
);
  sq_state_e st, nxt;
  logic [LEN_W-1:0] rem, rem_d;

  always_comb begin
    nxt   = st;
    rem_d = rem;
    unique case (st)
      SQ_IDLE: if (launch_i) nxt = SQ_REQ;
      SQ_REQ: if (req_ready_i) begin
        if (is_wr_i) begin
          nxt   = SQ_WR;
          rem_d = nbytes_i;
        end else begin
          nxt = SQ_WAIT;
        end
      end
      SQ_WR: if (wr_ready_i) begin
        rem_d = rem - 1'b1;
        if (rem == LEN_W'(1)) nxt = SQ_WAIT;
      end
      SQ_WAIT: if (rsp_valid_i) nxt = SQ_IDLE;
      default: nxt = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st  <= SQ_IDLE;
      rem <= '0;
    end else begin
      st  <= nxt;
      rem <= rem_d;
    end
  end

  assign busy_o      = (st != SQ_IDLE);
  assign req_valid_o = (st == SQ_REQ);
  assign wr_valid_o  = (st == SQ_WR);
  assign wr_pop_o    = (st == SQ_WR) && wr_ready_i;
  assign wait_o      = (st == SQ_WAIT);
endmodule

// File: rtl/aux_req_engine.sv
module aux_req_engine
  import aux_eng_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int LEN_W = $clog2(FIFO_DEPTH + 1),
  localparam int FCW   = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  output logic [7:0]        reg_rdata_o,
  output logic              lnk_req_valid_o,
  input  logic              lnk_req_ready_i,
  output logic [ADDR_W-1:0] lnk_req_addr_o,
  output logic [CMD_W-1:0]  lnk_req_cmd_o,
  output logic [LEN_W-1:0]  lnk_req_len_o,
  output logic              lnk_wr_valid_o,
  input  logic              lnk_wr_ready_i,
  output logic [7:0]        lnk_wr_data_o,
  input  logic              lnk_rd_valid_i,
  output logic              lnk_rd_ready_o,
  input  logic [7:0]        lnk_rd_data_i,
  input  logic              lnk_rsp_valid_i,
  output logic              lnk_rsp_ready_o,
  input  logic [OUTC_W-1:0] lnk_rsp_code_i,
  input  logic [RCNT_W-1:0] lnk_rsp_cnt_i
);
  logic [ADDR_W-1:0] adr_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [3:0]        lenm1_q;
  logic              nopl_q;
  logic [7:0]        stat_q;
  logic [7:0]        rdata_q;

  logic busy, wr_pop, waiting, host_we, launch, flush, rsp_take;
  logic is_rd, is_wr;
  logic [LEN_W-1:0] nbytes;
  logic [7:0] wf_head, rf_head;
  logic [FCW-1:0] wf_cnt, rf_cnt;

  // every host write is dropped while a request runs
  assign host_we  = reg_we_i && !busy;
  assign launch   = host_we && (reg_addr_i == OFS_CTL) && reg_wdata_i[0];
  assign flush    = host_we && (reg_addr_i == OFS_CFG) && (reg_wdata_i == CFG_FLUSH);
  assign rsp_take = lnk_rsp_valid_i && waiting;
  assign is_rd    = cmd_q[0];
  assign nbytes   = nopl_q ? '0 : LEN_W'(lenm1_q) + LEN_W'(1);
  assign is_wr    = !is_rd && (nbytes != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      adr_q   <= '0;
      cmd_q   <= '0;
      lenm1_q <= '0;
      nopl_q  <= 1'b0;
    end else if (host_we) begin
      unique case (reg_addr_i)
        OFS_ADR0: adr_q[7:0]   <= reg_wdata_i;
        OFS_ADR1: adr_q[15:8]  <= reg_wdata_i;
        OFS_ADR2: begin
          adr_q[19:16] <= reg_wdata_i[3:0];
          cmd_q        <= reg_wdata_i[7:4];
        end
        OFS_LEN: begin
          lenm1_q <= reg_wdata_i[3:0];
          nopl_q  <= reg_wdata_i[7];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       stat_q <= '0;
    else if (flush)    stat_q <= '0;
    else if (rsp_take) stat_q <= {lnk_rsp_code_i, lnk_rsp_cnt_i};
  end

  logic [7:0] rd_mux;
  always_comb begin
    unique case (reg_addr_i)
      OFS_ADR0: rd_mux = adr_q[7:0];
      OFS_ADR1: rd_mux = adr_q[15:8];
      OFS_ADR2: rd_mux = {cmd_q, adr_q[19:16]};
      OFS_LEN:  rd_mux = {nopl_q, 3'b000, lenm1_q};
      OFS_RDAT: rd_mux = rf_head;
      OFS_CTL:  rd_mux = {7'd0, busy};
      OFS_STAT: rd_mux = stat_q;
      default:  rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (reg_re_i) rdata_q <= rd_mux;
  end

  aux_seq #(.LEN_W(LEN_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .launch_i    (launch),
    .is_wr_i     (is_wr),
    .nbytes_i    (nbytes),
    .req_ready_i (lnk_req_ready_i),
    .wr_ready_i  (lnk_wr_ready_i),
    .rsp_valid_i (lnk_rsp_valid_i),
    .busy_o      (busy),
    .req_valid_o (lnk_req_valid_o),
    .wr_valid_o  (lnk_wr_valid_o),
    .wr_pop_o    (wr_pop),
    .wait_o      (waiting)
  );

  aux_byte_fifo #(.DEPTH(FIFO_DEPTH), .DW(8)) u_wfifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .push_i  (host_we && (reg_addr_i == OFS_WDAT)),
    .data_i  (reg_wdata_i),
    .pop_i   (wr_pop),
    .head_o  (wf_head),
    .cnt_o   (wf_cnt)
  );

  aux_byte_fifo #(.DEPTH(FIFO_DEPTH), .DW(8)) u_rfifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .push_i  (lnk_rd_valid_i && waiting && is_rd),
    .data_i  (lnk_rd_data_i),
    .pop_i   (reg_re_i && (reg_addr_i == OFS_RDAT)),
    .head_o  (rf_head),
    .cnt_o   (rf_cnt)
  );

  assign reg_rdata_o     = rdata_q;
  assign lnk_req_addr_o  = adr_q;
  assign lnk_req_cmd_o   = cmd_q;
  assign lnk_req_len_o   = nbytes;
  assign lnk_wr_data_o   = wf_head;
  assign lnk_rd_ready_o  = waiting;
  assign lnk_rsp_ready_o = waiting;
endmodule

// File: rtl/aux_req_engine_chk.sv
module aux_req_engine_chk
  import aux_eng_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int LEN_W = $clog2(FIFO_DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [7:0]        reg_addr_i,
  input logic              reg_we_i,
  input logic              lnk_req_valid_o,
  input logic              lnk_req_ready_i,
  input logic [ADDR_W-1:0] lnk_req_addr_o,
  input logic [CMD_W-1:0]  lnk_req_cmd_o,
  input logic [LEN_W-1:0]  lnk_req_len_o,
  input logic              lnk_wr_valid_o,
  input logic              lnk_rsp_valid_i,
  input logic              lnk_rsp_ready_o,
  input logic [LEN_W-1:0]  wcnt,
  input logic [LEN_W-1:0]  rcnt
);
  a_r4_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lnk_req_valid_o && !lnk_req_ready_i |=> lnk_req_valid_o && $stable(lnk_req_addr_o)
      && $stable(lnk_req_cmd_o) && $stable(lnk_req_len_o));

  a_r4_one_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({lnk_req_valid_o, lnk_wr_valid_o, lnk_rsp_ready_o}));

  a_r4_launch_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lnk_req_valid_o) |-> $past(reg_we_i && (reg_addr_i == OFS_CTL)));

  a_r5_wr_only_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lnk_wr_valid_o |-> !lnk_req_cmd_o[0] && (lnk_req_len_o != '0));

  a_r7_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lnk_rsp_valid_i && lnk_rsp_ready_o |=> !lnk_rsp_ready_o && !lnk_req_valid_o && !lnk_wr_valid_o);

  a_r9_addr_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lnk_rsp_ready_o && reg_we_i && (reg_addr_i == OFS_ADR0) |=> $stable(lnk_req_addr_o));

  a_r8_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wcnt <= LEN_W'(FIFO_DEPTH)) && (rcnt <= LEN_W'(FIFO_DEPTH)));
endmodule

bind aux_req_engine aux_req_engine_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .reg_addr_i      (reg_addr_i),
  .reg_we_i        (reg_we_i),
  .lnk_req_valid_o (lnk_req_valid_o),
  .lnk_req_ready_i (lnk_req_ready_i),
  .lnk_req_addr_o  (lnk_req_addr_o),
  .lnk_req_cmd_o   (lnk_req_cmd_o),
  .lnk_req_len_o   (lnk_req_len_o),
  .lnk_wr_valid_o  (lnk_wr_valid_o),
  .lnk_rsp_valid_i (lnk_rsp_valid_i),
  .lnk_rsp_ready_o (lnk_rsp_ready_o),
  .wcnt            (wf_cnt),
  .rcnt            (rf_cnt)
);

// File: tb/aux_req_engine_tb.sv
module aux_req_engine_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [7:0] reg_addr_i = '0, reg_wdata_i = '0, reg_rdata_o;
  logic reg_we_i = 1'b0, reg_re_i = 1'b0;
  logic lnk_req_valid_o, lnk_req_ready_i = 1'b0;
  logic [19:0] lnk_req_addr_o;
  logic [3:0] lnk_req_cmd_o;
  logic [4:0] lnk_req_len_o;
  logic lnk_wr_valid_o, lnk_wr_ready_i = 1'b0;
  logic [7:0] lnk_wr_data_o;
  logic lnk_rd_valid_i = 1'b0, lnk_rd_ready_o;
  logic [7:0] lnk_rd_data_i = '0;
  logic lnk_rsp_valid_i = 1'b0, lnk_rsp_ready_o;
  logic [2:0] lnk_rsp_code_i = '0;
  logic [4:0] lnk_rsp_cnt_i = '0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aux_req_engine u_dut (.*, .clk_i(clk));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_len(input logic [7:0] v);
    return v[7] ? 5'd0 : 5'(v[3:0]) + 5'd1;
  endfunction

  task automatic host_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic host_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr_i = a; reg_re_i = 1'b1;
    @(negedge clk);
    reg_re_i = 1'b0;
    d = reg_rdata_o;
  endtask

  task automatic txn(input logic [19:0] a, input logic [3:0] c, input int nb, input int npush,
                     input int nrd, input logic [2:0] oc, input logic [4:0] rc,
                     input bit flush, input bit poke);
    logic [7:0] wb [16];
    logic [7:0] rb [24];
    logic [7:0] v, e;
    int nexp;
    if (flush) host_wr(8'h76, 8'hFF);
    host_wr(8'h7D, a[7:0]);
    host_wr(8'h7E, a[15:8]);
    host_wr(8'h7F, {c, a[19:16]});
    host_wr(8'h80, (nb == 0) ? 8'h80 : 8'(nb - 1));
    for (int i = 0; i < npush; i++) begin
      v = 8'($urandom);
      if (i < 16) wb[i] = v;
      host_wr(8'h81, v);
    end
    if (poke) host_wr(8'h76, 8'h12);
    host_wr(8'h83, 8'h01);
    chk(lnk_req_valid_o == 1'b1, "R4 req_valid", int'(lnk_req_valid_o), 1);
    chk(lnk_req_addr_o == a, "R2 addr", int'(lnk_req_addr_o), int'(a));
    chk(lnk_req_cmd_o == c, "R2 cmd", int'(lnk_req_cmd_o), int'(c));
    chk(lnk_req_len_o == 5'(nb), "R3 len", int'(lnk_req_len_o), nb);
    host_rd(8'h83, v);
    chk(v == 8'h01, "R4 busy", int'(v), 1);
    host_wr(8'h7D, ~a[7:0]);
    host_wr(8'h76, 8'hFF);
    host_wr(8'h83, 8'h01);
    chk(lnk_req_addr_o == a, "R9 addr held", int'(lnk_req_addr_o), int'(a));
    chk(lnk_req_valid_o == 1'b1, "R4 hold", int'(lnk_req_valid_o), 1);
    repeat ($urandom_range(0, 3)) @(negedge clk);
    lnk_req_ready_i = 1'b1;
    @(negedge clk);
    lnk_req_ready_i = 1'b0;
    if (!c[0] && nb > 0) begin
      for (int k = 0; k < nb; k++) begin
        e = (k < npush && k < 16) ? wb[k] : 8'h00;
        chk(lnk_wr_valid_o && lnk_wr_data_o == e, "R5 wr byte", int'(lnk_wr_data_o), int'(e));
        lnk_wr_ready_i = 1'b1;
        @(negedge clk);
      end
      lnk_wr_ready_i = 1'b0;
    end
    chk(!lnk_wr_valid_o && lnk_rsp_ready_o, "R5 wr end", int'(lnk_wr_valid_o), 0);
    for (int j = 0; j < nrd; j++) begin
      v = 8'($urandom);
      if (j < 24) rb[j] = v;
      lnk_rd_valid_i = 1'b1; lnk_rd_data_i = v;
      @(negedge clk);
    end
    lnk_rd_valid_i = 1'b0;
    lnk_rsp_valid_i = 1'b1; lnk_rsp_code_i = oc; lnk_rsp_cnt_i = rc;
    @(negedge clk);
    lnk_rsp_valid_i = 1'b0;
    chk(!lnk_req_valid_o && !lnk_rsp_ready_o, "R7 idle", int'(lnk_rsp_ready_o), 0);
    host_rd(8'h83, v);
    chk(v == 8'h00, "R7 busy clear", int'(v), 0);
    host_rd(8'h84, v);
    chk(v == {oc, rc}, "R7 status", int'(v), int'({oc, rc}));
    host_rd(8'h7D, v);
    chk(v == a[7:0], "R9 adr0 kept", int'(v), int'(a[7:0]));
    nexp = c[0] ? ((nrd < 16) ? nrd : 16) : 0;
    for (int j = 0; j < nexp; j++) begin
      host_rd(8'h82, v);
      chk(v == rb[j], "R6 rd byte", int'(v), int'(rb[j]));
    end
    host_rd(8'h82, v);
    chk(v == 8'h00, c[0] ? "R8 empty pop" : "R6 discarded", int'(v), 0);
  endtask

  initial begin
    logic [7:0] v;
    logic [3:0] codes [6];
    v = 8'($urandom(32'd20240917));
    codes = '{4'h8, 4'h9, 4'h0, 4'h1, 4'h4, 4'h5};
    repeat (3) @(negedge clk);
    chk(!lnk_req_valid_o && !lnk_wr_valid_o && !lnk_rsp_ready_o, "R1 outputs", 0, 0);
    rst_ni = 1'b1;
    for (int a = 8'h7D; a <= 8'h84; a++) begin
      host_rd(8'(a), v);
      chk(v == 8'h00, "R1 reg reset", int'(v), 0);
    end
    // length encoding
    host_wr(8'h80, 8'hF5);
    host_rd(8'h80, v);
    chk(v == 8'h85, "R3 len readback", int'(v), 8'h85);
    chk(lnk_req_len_o == exp_len(8'hF5), "R3 nopl", int'(lnk_req_len_o), 0);
    host_wr(8'h80, 8'h07);
    chk(lnk_req_len_o == exp_len(8'h07), "R3 len8", int'(lnk_req_len_o), 8);
    host_wr(8'h7F, 8'hA3);
    host_rd(8'h7F, v);
    chk(v == 8'hA3, "R2 adr2 readback", int'(v), 8'hA3);
    chk(lnk_req_cmd_o == 4'hA && lnk_req_addr_o[19:16] == 4'h3, "R2 packing",
        int'(lnk_req_cmd_o), 10);
    // directed cases
    txn(20'hABCDE, 4'h8, 4, 2, 0, 3'd3, 5'd4, 1, 0);    // short write queue, zero fill
    txn(20'h12345, 4'h8, 16, 18, 0, 3'd3, 5'd16, 1, 0); // write overflow
    txn(20'hFFFFF, 4'h9, 16, 0, 19, 3'd3, 5'd16, 1, 0); // read overflow
    txn(20'h00001, 4'h1, 0, 0, 0, 3'd5, 5'd0, 1, 0);     // no payload read
    txn(20'h00050, 4'h0, 0, 3, 0, 3'd1, 5'd0, 1, 0);     // no payload write
    txn(20'h00AA0, 4'h0, 3, 3, 2, 3'd3, 5'd3, 1, 0);     // write discards returns
    txn(20'h4A5A5, 4'h8, 2, 2, 0, 3'd3, 5'd2, 1, 1);     // R10 non-flush value
    // R10 flush empties queues and status
    host_wr(8'h81, 8'h5A);
    host_wr(8'h81, 8'hC3);
    host_wr(8'h76, 8'hFF);
    host_rd(8'h84, v);
    chk(v == 8'h00, "R10 status cleared", int'(v), 0);
    txn(20'h0F0F0, 4'h8, 2, 0, 0, 3'd7, 5'd0, 0, 0);
    for (int n = 0; n < 40; n++) begin
      logic [3:0] c;
      int nb;
      c  = codes[$urandom_range(0, 5)];
      nb = $urandom_range(0, 16);
      txn(20'($urandom), c, nb, c[0] ? 0 : nb, c[0] ? $urandom_range(0, 18) : $urandom_range(0, 2),
          3'($urandom_range(1, 7)), 5'($urandom), 1, 0);
    end
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule